// File: doc/BRIEF.md
# Two-Level Rotating Bus Arbiter

This block decides which of nine masters may drive a shared parallel bus with a
cycle-framed protocol. Master index 0 is the internal bridge master and indices
1 to 8 are the external masters 0 to 7. Requests arrive active-low, and grants
leave active-low. The arbiter also watches the bus start-of-cycle strobe (`frame_ni`)
and the initiator-ready strobe (`irdy_ni`) to tell whether the bus is busy.

A 9-bit group-select word places each master in a high or a low group. Priority
rotates inside each group. The low group as a whole holds one turn that follows
each full pass through the high group, so with n high members the high group wins
n transactions in every n+1. Priorities are recomputed only when a new transaction
begins. Between those points the grant follows the best request that is present,
preempting a weaker one. A grant that goes unused on an idle bus expires. On an
idle bus a grant handover always passes through one cycle with no grant.

Top module: `two_lvl_arb`

## Requirements
- R1: While `rst_ni` is low all grants are deasserted. After reset only index 0 is in the high group, so with every master requesting the first grant goes to index 0.
- R2: A write on the configuration port stores `cfg_wdata_i` as the group word (bit i = 1 puts master i in the high group). The stored word takes effect only when the next transaction starts, meaning the first cycle in which `frame_ni` is sampled low after being high.
- R3: When both groups are non-empty and all masters keep requesting, the high members are served in ascending index order, one after another. After each n high transactions one low member is served, and that turn moves through the low members in ascending index order.
- R4: When every master is in the same group, service is plain rotation over all nine indices in ascending order.
- R5: At each transaction start, the master holding the grant becomes the lowest-priority member of its group, and the next index above it in that group becomes the highest.
- R6: Between transaction starts, the grant goes to the highest-priority asserted request. A newly asserted grant always belongs to a master that was requesting in the previous cycle. A stronger request withdraws a weaker grant that is already asserted.
- R7: If a grant stays asserted for 16 cycles with the bus idle (`frame_ni` and `irdy_ni` both high), it is removed after the 16th cycle. That master is then passed over until it releases its request or a transaction starts.
- R8: With the bus idle, a grant never moves directly from one master to another. At least one cycle with no grant lies between them.
- R9: With the bus busy (`frame_ni` or `irdy_ni` low), the grant may move from one master to another at a single clock edge.
- R10: At most one grant is asserted in any cycle.
- R11: With no request asserted, the current grant is held (bus parking).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | 9 | Requests, active low, index 0 = bridge master |
| frame_ni | input | 1 | Bus start-of-cycle strobe, active low |
| irdy_ni | input | 1 | Initiator-ready strobe, active low |
| cfg_we_i | input | 1 | Group word write enable |
| cfg_wdata_i | input | 9 | Group word write data, bit i = 1 means high group |
| gnt_no | output | 9 | Grants, active low, at most one low |

## Verification
Preemption and grant-turnover spacing can act in the same cycle. This happens when a stronger request arrives while a weaker master holds the grant. The bench provokes it twice. The first time the bus is idle, and the expected result is one cycle with no grant followed by the stronger grant. The second time `irdy_ni` is held low, and the stronger grant must replace the weaker one at one edge. The timeout is then run on the grant gained by preemption, to check that the expired master is passed over and the waiting master takes the bus.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned ARB_TO_CYC_DEF = 16;

  typedef enum logic {
    GRP_HI = 1'b0,
    GRP_LO = 1'b1
  } grp_e;
endpackage

// File: rtl/arb_rr_pick.sv
// Rotating pick: first candidate strictly after last_i, wrapping.
module arb_rr_pick #(
  parameter int NM = 9,
  parameter int IW = 4
) (
  input  logic [NM-1:0] cand_i,
  input  logic [IW-1:0] last_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  localparam int SW = IW + 1;

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    // walk from farthest to nearest so the nearest hit is kept
    for (int o = NM; o >= 1; o--) begin
      logic [SW-1:0] j;
      j = {1'b0, last_i} + SW'(o);
      if (j >= SW'(NM)) j = j - SW'(NM);
      if (cand_i[j[IW-1:0]]) begin
        any_o = 1'b1;
        idx_o = j[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/arb_sched.sv
// Group word, rotation pointers and low-turn bookkeeping.
module arb_sched #(
  parameter int NM = 9,
  parameter int IW = 4,
  parameter int CNW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [NM-1:0] cfg_wdata_i,
  input  logic          frame_ni,
  input  logic [NM-1:0] gnt_i,
  output logic [NM-1:0] grp_act_o,
  output logic [IW-1:0] hi_ptr_o,
  output logic [IW-1:0] lo_ptr_o,
  output logic          lo_turn_o,
  output logic          frame_start_o
);
  localparam logic [NM-1:0] GRP_RST = NM'(1);

  logic [NM-1:0]  grp_q, grp_act_q;
  logic [IW-1:0]  hi_ptr_q, lo_ptr_q, own_idx;
  logic [CNW-1:0] hi_cnt_q, n_hi;
  logic           frame_q, own_vld;

  assign frame_start_o = frame_q & ~frame_ni;
  assign own_vld       = |gnt_i;

  always_comb begin
    own_idx = '0;
    for (int i = 0; i < NM; i++) if (gnt_i[i]) own_idx = IW'(i);
  end

  always_comb begin
    n_hi = '0;
    for (int i = 0; i < NM; i++) n_hi = n_hi + CNW'(grp_act_q[i]);
  end

  assign lo_turn_o = (hi_cnt_q >= n_hi);
  assign grp_act_o = grp_act_q;
  assign hi_ptr_o  = hi_ptr_q;
  assign lo_ptr_o  = lo_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q     <= GRP_RST;
      grp_act_q <= GRP_RST;
      hi_ptr_q  <= IW'(NM - 1);
      lo_ptr_q  <= IW'(NM - 1);
      hi_cnt_q  <= '0;
      frame_q   <= 1'b1;
    end else begin
      frame_q <= frame_ni;
      if (cfg_we_i) grp_q <= cfg_wdata_i;
      if (frame_start_o) begin
        grp_act_q <= grp_q;
        if (own_vld) begin
          if (grp_q[own_idx]) begin
            hi_ptr_q <= own_idx;
            if (hi_cnt_q != CNW'(NM)) hi_cnt_q <= hi_cnt_q + 1'b1;
          end else begin
            lo_ptr_q <= own_idx;
            hi_cnt_q <= '0;
          end
        end
      end
    end
  end

  // R2
  cfg_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_o |=> $stable(grp_act_q));

  // R5
  own_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_o && own_vld && grp_q[own_idx]) |=> (hi_ptr_q == $past(own_idx)));
endmodule

// File: rtl/arb_gnt_ctrl.sv
// Grant register, idle-bus timeout and handover spacing.
module arb_gnt_ctrl #(
  parameter int NM = 9,
  parameter int TO_CYC = 16,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NM-1:0] tgt_i,
  input  logic          idle_i,
  output logic [NM-1:0] gnt_o,
  output logic          to_fire_o
);
  logic [NM-1:0] gnt_q, gnt_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          held;

  assign held      = |gnt_q;
  assign to_fire_o = held && idle_i && (cnt_q == CW'(TO_CYC - 1));

  always_comb begin
    gnt_d = gnt_q;
    if (to_fire_o)
      gnt_d = '0;
    else if (tgt_i != gnt_q)
      gnt_d = (idle_i && held) ? '0 : tgt_i;  // dead cycle only on idle bus
  end

  always_comb begin
    if (gnt_d != gnt_q || !idle_i || !held) cnt_d = '0;
    else cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q <= '0;
      cnt_q <= '0;
    end else begin
      gnt_q <= gnt_d;
      cnt_q <= cnt_d;
    end
  end

  assign gnt_o = gnt_q;

  // R10
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));

  // R8
  idle_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(idle_i) && ($past(gnt_q) != '0) && (gnt_q != '0)) |-> (gnt_q == $past(gnt_q)));

  // R7
  timeout_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && idle_i && cnt_q == CW'(TO_CYC - 1)) |=> (gnt_q == '0));
endmodule

// File: rtl/two_lvl_arb.sv
module two_lvl_arb
  import arb_pkg::*;
#(
  parameter int N_EXT  = 8,
  parameter int TO_CYC = int'(ARB_TO_CYC_DEF)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_EXT:0]     req_ni,
  input  logic               frame_ni,
  input  logic               irdy_ni,
  input  logic               cfg_we_i,
  input  logic [N_EXT:0]     cfg_wdata_i,
  output logic [N_EXT:0]     gnt_no
);
  localparam int NM  = N_EXT + 1;
  localparam int IW  = (NM > 1) ? $clog2(NM) : 1;
  localparam int CNW = $clog2(NM + 1);
  localparam int CW  = $clog2(TO_CYC + 1);

  logic [NM-1:0] grp_act, cand, tgt, gnt_q, to_mask_q, to_mask_d;
  logic [IW-1:0] hi_ptr, lo_ptr, win_idx;
  logic          lo_turn, frame_start, idle, to_fire, any_req;
  grp_e          win_grp;

  logic [NM-1:0] pick_mask [2];
  logic [IW-1:0] pick_last [2];
  logic [IW-1:0] pick_idx  [2];
  logic          pick_any  [2];

  assign idle = frame_ni & irdy_ni;
  assign cand = ~req_ni & ~to_mask_q;

  arb_sched #(.NM(NM), .IW(IW), .CNW(CNW)) u_sched (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_we_i     (cfg_we_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .frame_ni     (frame_ni),
    .gnt_i        (gnt_q),
    .grp_act_o    (grp_act),
    .hi_ptr_o     (hi_ptr),
    .lo_ptr_o     (lo_ptr),
    .lo_turn_o    (lo_turn),
    .frame_start_o(frame_start)
  );

  for (genvar g = 0; g < 2; g++) begin : g_pick
    if (g == int'(GRP_HI)) begin : g_hi
      assign pick_mask[g] = grp_act;
      assign pick_last[g] = hi_ptr;
    end else begin : g_lo
      assign pick_mask[g] = ~grp_act;
      assign pick_last[g] = lo_ptr;
    end
    arb_rr_pick #(.NM(NM), .IW(IW)) u_pick (
      .cand_i(cand & pick_mask[g]),
      .last_i(pick_last[g]),
      .any_o (pick_any[g]),
      .idx_o (pick_idx[g])
    );
  end

  // low turn comes first only after a full pass of the high group
  always_comb begin
    if (lo_turn) win_grp = pick_any[GRP_LO] ? GRP_LO : GRP_HI;
    else         win_grp = pick_any[GRP_HI] ? GRP_HI : GRP_LO;
  end

  assign win_idx = pick_idx[win_grp];
  assign any_req = pick_any[GRP_HI] | pick_any[GRP_LO];
  assign tgt     = any_req ? (NM'(1) << win_idx) : gnt_q;

  arb_gnt_ctrl #(.NM(NM), .TO_CYC(TO_CYC), .CW(CW)) u_gnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tgt_i    (tgt),
    .idle_i   (idle),
    .gnt_o    (gnt_q),
    .to_fire_o(to_fire)
  );

  // timed-out master is passed over until it lets go or a transaction starts
  always_comb begin
    to_mask_d = frame_start ? '0 : (to_mask_q & ~req_ni);
    if (to_fire) to_mask_d = to_mask_d | gnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) to_mask_q <= '0;
    else         to_mask_q <= to_mask_d;
  end

  assign gnt_no = ~gnt_q;

  // R6
  gnt_to_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_q != '0) && (gnt_q != $past(gnt_q))) |-> ((gnt_q & ~$past(req_ni)) != '0));

  // R11
  park_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_ni == '1) && !to_fire) |=> $stable(gnt_q));
endmodule

// File: tb/two_lvl_arb_tb_top.sv
`timescale 1ns/1ps
module two_lvl_arb_tb_top;
  localparam int NM = 9;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NM-1:0] req_ni = '1;
  logic          frame_ni = 1'b1;
  logic          irdy_ni = 1'b1;
  logic          cfg_we = 1'b0;
  logic [NM-1:0] cfg_wdata = '0;
  logic [NM-1:0] gnt_no;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  two_lvl_arb dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .req_ni     (req_ni),
    .frame_ni   (frame_ni),
    .irdy_ni    (irdy_ni),
    .cfg_we_i   (cfg_we),
    .cfg_wdata_i(cfg_wdata),
    .gnt_no     (gnt_no)
  );

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int gidx();
    int r = -1;
    for (int i = NM - 1; i >= 0; i--) if (!gnt_no[i]) r = i;
    return r;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
    check($countones(~gnt_no) <= 1, "R10", "grants asserted", $countones(~gnt_no), 1);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; req_ni = '1; frame_ni = 1'b1; irdy_ni = 1'b1; cfg_we = 1'b0;
    repeat (3) tick();
    check(gnt_no == '1, "R1", "grants during reset", int'(gnt_no), (1 << NM) - 1);
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic write_cfg(input logic [NM-1:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic run_txn(output int who);
    int w = 0;
    while (gidx() < 0 && w < 40) begin tick(); w++; end
    who = gidx();
    frame_ni = 1'b0; irdy_ni = 1'b0;
    tick();
    frame_ni = 1'b1;
    tick();
    irdy_ni = 1'b1;
  endtask

  // R3 R4 R5: rotation sweep with expected order from group counts
  task automatic sweep(input logic [NM-1:0] cfg);
    int hl[NM]; int ll[NM]; int n = 0; int m = 0; int who; int exp;
    for (int i = 0; i < NM; i++) begin
      if (cfg[i]) begin hl[n] = i; n++; end
      else        begin ll[m] = i; m++; end
    end
    do_reset();
    write_cfg(cfg);
    req_ni = ~NM'(1);
    run_txn(who);
    check(who == 0, "R5", "seed initiator", who, 0);
    req_ni = '0;
    tick(); tick();
    for (int j = 0; j < 18; j++) begin
      int k = j + 1;
      run_txn(who);
      if (n == 0 || m == 0) begin
        exp = k % NM;
        check(who == exp, "R4", "single-group rotation", who, exp);
      end else begin
        int pos = k % (n + 1);
        int blk = k / (n + 1);
        exp = (pos < n) ? hl[pos] : ll[blk % m];
        check(who == exp, "R3", "two-level rotation", who, exp);
      end
    end
  endtask

  initial begin
    // R1: default groups favour the bridge
    do_reset();
    req_ni = '0;
    tick();
    check(gidx() == 0, "R1", "first grant after reset", gidx(), 0);

    // R2: new group word not active before a transaction starts
    do_reset();
    write_cfg(NM'(9'b000010000));
    req_ni = ~NM'(9'b000010001);
    tick();
    check(gidx() == 0, "R2", "grant under old groups", gidx(), 0);

    // R6 R8 R7 R11: preemption on idle bus, then timeout, then parking
    do_reset();
    req_ni = ~NM'(9'b000010000);
    tick();
    check(gidx() == 4, "R6", "lone requester granted", gidx(), 4);
    req_ni = ~NM'(9'b000010001);
    tick();
    check(gidx() == -1, "R8", "dead cycle at idle handover", gidx(), -1);
    tick();
    check(gidx() == 0, "R6", "stronger request preempts", gidx(), 0);
    for (int i = 1; i < 16; i++) begin
      tick();
      check(gidx() == 0, "R7", "grant held before timeout", gidx(), 0);
    end
    tick();
    check(gidx() == -1, "R7", "grant removed after 16 idle cycles", gidx(), -1);
    tick();
    check(gidx() == 4, "R7", "timed-out master passed over", gidx(), 4);
    req_ni = '1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(gidx() == 4, "R11", "parked grant held", gidx(), 4);
    end

    // R9: busy bus allows direct handover
    do_reset();
    req_ni = ~NM'(9'b000010000);
    tick();
    check(gidx() == 4, "R9", "initial grant", gidx(), 4);
    irdy_ni = 1'b0;
    req_ni = ~NM'(9'b000010001);
    tick();
    check(gidx() == 0, "R9", "direct handover on busy bus", gidx(), 0);
    irdy_ni = 1'b1;

    // rotation over every high-group choice containing the bridge, plus all-low
    for (int e = 0; e < 256; e++) sweep({e[7:0], 1'b1});
    sweep('0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule